// File: doc/BRIEF.md
# Comparator Event Interrupt Controller

This block is the digital side of an on-chip voltage comparator. It brings the raw comparator decision into the system clock domain through a multi-stage synchronizer. It watches the synchronized level for changes selected by a two-bit mode. It records a matching change in a sticky flag and raises an interrupt request when the flag, a local enable and the global CPU interrupt enable are all set.

A single status/control byte is read and written through a plain write-strobe port. Besides the mode and interrupt enable, the byte holds three control bits that are driven straight out of the block:

- a bit that makes the positive comparator input use the fixed internal reference instead of the external pin;
- a bit that routes the synchronized result to the timer's capture trigger;
- a storage bit driven out as a comparator disable.

The flag clears in two ways. Software can write a one to it. The CPU can also pulse an acknowledge line when it enters the matching interrupt vector.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: The raw comparator input reaches the synchronized level, read at status bit 5, exactly two clock edges after it is sampled. Bit 5 is read-only.
- R2: With mode code 00 in bits [1:0], both a rising and a falling change of the synchronized level set the flag (status bit 4).
- R3: With mode code 10, only a falling change (1 to 0) sets the flag.
- R4: With mode code 11, only a rising change (0 to 1) sets the flag.
- R5: Mode code 01 is reserved. No change of the level sets the flag.
- R6: A write with bit 4 at one clears the flag. A write with bit 4 at zero leaves it unchanged.
- R7: A one-cycle pulse on `irq_ack` clears the flag.
- R8: If a detected change and a clear (by write or by acknowledge) fall in the same cycle, the flag ends set.
- R9: `irq` is high exactly when the flag, the interrupt enable (status bit 3) and `gie` are all one.
- R10: When the capture-enable bit (status bit 2) is one, `cap_trig` follows the synchronized level. When that bit is zero, `cap_trig` is low.
- R11: Bits 7, 6, 3, 2, 1 and 0 read back as written. Bit 6 drives `ref_sel`, where 1 selects the internal reference. Bit 7 drives `cmp_off`.
- R12: Reset clears every status bit and deasserts `irq`. A level that is already high when reset ends does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw | input | 1 | Asynchronous comparator decision |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Write data for the status byte |
| rd_data | output | 8 | Current status byte |
| gie | input | 1 | Global interrupt enable from the CPU |
| irq_ack | input | 1 | Pulse when the CPU enters the comparator vector |
| irq | output | 1 | Interrupt request |
| ref_sel | output | 1 | Positive-input mux select, 1 = internal reference |
| cap_trig | output | 1 | Capture trigger toward the timer |
| cmp_off | output | 1 | Comparator disable |

## Verification
Three things can hit the flag in the same clock: a hardware set from a detected level change, and a clear from either a software write of one or the acknowledge pulse. The bench finds this cycle by counting the synchronizer stages. It changes the raw input, waits until the edge detector sees the change on the synchronized level, and in that same cycle applies the clearing write in one test and the acknowledge pulse in another. In both tests the flag must already be set beforehand. The flag must then read one, which shows that the event was not lost to the clear.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evt_mode_e;

  localparam int STAT_W   = 8;
  localparam int BIT_OFF  = 7;
  localparam int BIT_REF  = 6;
  localparam int BIT_LVL  = 5;
  localparam int BIT_FLAG = 4;
  localparam int BIT_IE   = 3;
  localparam int BIT_CAP  = 2;
endpackage

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shreg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = shreg[STAGES-1];
endmodule

// File: rtl/cmp_evt_edge.sv
module cmp_evt_edge
  import cmp_evt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl,
  input  evt_mode_e mode,
  output logic      evt
);
  localparam int CW = $clog2(STAGES + 2);
  localparam logic [CW-1:0] ARM_AT = CW'(STAGES + 1);

  logic [CW-1:0] warm_cnt;
  logic          prev;
  logic          armed;

  assign armed = (warm_cnt == ARM_AT);

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_cnt <= '0;
      prev     <= 1'b0;
    end else begin
      prev <= lvl;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  always_comb begin
    case (mode)
      MODE_ANY:  evt = armed & (lvl ^ prev);
      MODE_FALL: evt = armed & prev & ~lvl;
      MODE_RISE: evt = armed & ~prev & lvl;
      default:   evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
  import cmp_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              set_evt,
  input  logic              ack,
  input  logic              lvl,
  output logic [STAT_W-1:0] status,
  output logic              flag,
  output logic              ie,
  output logic              cap_en,
  output logic              ref_sel,
  output logic              off,
  output evt_mode_e         mode
);
  logic sw_clr;

  assign sw_clr = wr_en & wr_data[BIT_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      off     <= 1'b0;
      ref_sel <= 1'b0;
      ie      <= 1'b0;
      cap_en  <= 1'b0;
      mode    <= MODE_ANY;
    end else if (wr_en) begin
      off     <= wr_data[BIT_OFF];
      ref_sel <= wr_data[BIT_REF];
      ie      <= wr_data[BIT_IE];
      cap_en  <= wr_data[BIT_CAP];
      mode    <= evt_mode_e'(wr_data[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  flag <= 1'b0;
    else if (set_evt)         flag <= 1'b1;
    else if (sw_clr || ack)   flag <= 1'b0;
  end

  assign status = {off, ref_sel, lvl, flag, ie, cap_en, mode};
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmp_raw,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       gie,
  input  logic       irq_ack,
  output logic       irq,
  output logic       ref_sel,
  output logic       cap_trig,
  output logic       cmp_off
);
  logic      lvl;
  logic      evt;
  logic      flag;
  logic      ie;
  logic      cap_en;
  evt_mode_e mode;

  cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cmp_raw),
    .dout (lvl)
  );

  cmp_evt_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl),
    .mode (mode),
    .evt  (evt)
  );

  cmp_evt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .set_evt (evt),
    .ack     (irq_ack),
    .lvl     (lvl),
    .status  (rd_data),
    .flag    (flag),
    .ie      (ie),
    .cap_en  (cap_en),
    .ref_sel (ref_sel),
    .off     (cmp_off),
    .mode    (mode)
  );

  assign irq      = flag & ie & gie;
  assign cap_trig = cap_en & lvl;
endmodule

// File: rtl/cmp_evt_ctrl_chk.sv
module cmp_evt_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       gie,
  input logic       irq_ack,
  input logic       irq,
  input logic       cap_trig,
  input logic       evt
);
  a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
    evt |=> rd_data[4]);

  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (rd_data[1:0] == 2'b01) |-> !evt);

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !evt) |=> !rd_data[4]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (evt && (irq_ack || (wr_en && wr_data[4]))) |=> rd_data[4]);

  a_r9_irq_needs_all: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rd_data[4] && rd_data[3] && gie));

  a_r9_irq_when_all: assert property (@(posedge clk) disable iff (rst)
    (rd_data[4] && rd_data[3] && gie) |-> irq);

  a_r10_capture_gated: assert property (@(posedge clk) disable iff (rst)
    !rd_data[2] |-> !cap_trig);

  a_r12_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 8'h00 && !irq));
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .gie      (gie),
  .irq_ack  (irq_ack),
  .irq      (irq),
  .cap_trig (cap_trig),
  .evt      (evt)
);

// File: tb/cmp_evt_ctrl_bench.sv
module cmp_evt_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmp_raw = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       gie = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       ref_sel;
  logic       cap_trig;
  logic       cmp_off;

  int checks = 0;
  int failures = 0;

  // {mode[1:0], level before, level after, expected flag}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00011, 5'b00101, 5'b10010, 5'b10101,
    5'b11011, 5'b11100, 5'b01010, 5'b01100
  };

  cmp_evt_ctrl u_cmp_evt_ctrl (
    .clk(clk), .rst(rst), .cmp_raw(cmp_raw), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .gie(gie), .irq_ack(irq_ack), .irq(irq),
    .ref_sel(ref_sel), .cap_trig(cap_trig), .cmp_off(cmp_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  // mode 00: toggle raw and let the flag set
  task automatic raise_flag();
    cmp_raw = ~cmp_raw;
    idle(5);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R12: reset state
    check("R12 status", rd_data, 8'h00);
    check("R12 irq", {7'b0, irq}, 8'h00);

    // vector table over modes R2..R5
    foreach (VEC[k]) begin
      logic [1:0] m;
      string tag;
      m = VEC[k][4:3];
      tag = (m == 2'b00) ? "R2" : (m == 2'b10) ? "R3" : (m == 2'b11) ? "R4" : "R5";
      wr({4'b0001, 2'b00, m});
      cmp_raw = VEC[k][2];
      idle(5);
      wr({4'b0001, 2'b00, m});
      cmp_raw = VEC[k][1];
      idle(5);
      check(tag, {7'b0, rd_data[4]}, {7'b0, VEC[k][0]});
    end

    // R1: latency of the synchronizer
    wr(8'h10);
    cmp_raw = 1'b0;
    idle(4);
    cmp_raw = 1'b1;
    @(negedge clk);
    check("R1 one edge", {7'b0, rd_data[5]}, 8'h00);
    @(negedge clk);
    check("R1 two edges", {7'b0, rd_data[5]}, 8'h01);
    wr(8'h30);
    check("R1 read-only", {7'b0, rd_data[5]}, 8'h01);

    // R6: write one clears, zero keeps
    wr(8'h10);
    raise_flag();
    wr(8'h00);
    check("R6 write zero", {7'b0, rd_data[4]}, 8'h01);
    wr(8'h10);
    check("R6 write one", {7'b0, rd_data[4]}, 8'h00);

    // R7: acknowledge clears
    raise_flag();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R7 ack", {7'b0, rd_data[4]}, 8'h00);

    // R8: set wins over write clear (flag already set)
    raise_flag();
    cmp_raw = ~cmp_raw;
    idle(2);
    wr(8'h10);
    check("R8 vs write", {7'b0, rd_data[4]}, 8'h01);
    idle(3);
    // R8: set wins over ack
    cmp_raw = ~cmp_raw;
    idle(2);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R8 vs ack", {7'b0, rd_data[4]}, 8'h01);

    // R9: irq gating (flag is set, mode 00)
    wr(8'h08);
    gie = 1'b0;
    #1 check("R9 gie low", {7'b0, irq}, 8'h00);
    gie = 1'b1;
    #1 check("R9 all set", {7'b0, irq}, 8'h01);
    @(negedge clk);
    wr(8'h00);
    check("R9 ie low", {7'b0, irq}, 8'h00);
    gie = 1'b0;

    // R10: capture routing
    cmp_raw = 1'b1;
    idle(4);
    wr(8'h04);
    check("R10 enabled", {7'b0, cap_trig}, 8'h01);
    cmp_raw = 1'b0;
    idle(3);
    check("R10 follows", {7'b0, cap_trig}, 8'h00);
    cmp_raw = 1'b1;
    idle(3);
    wr(8'h00);
    check("R10 disabled", {7'b0, cap_trig}, 8'h00);

    // R11: readback and control outputs
    wr(8'hCE);
    check("R11 readback", rd_data & 8'hCF, 8'hCE);
    check("R11 outs", {6'b0, cmp_off, ref_sel}, 8'h03);
    wr(8'h41);
    check("R11 readback2", rd_data & 8'hCF, 8'h41);
    check("R11 outs2", {6'b0, cmp_off, ref_sel}, 8'h01);

    // R12: high level through reset gives no spurious flag
    cmp_raw = 1'b1;
    do_reset();
    check("R12 cleared", rd_data, 8'h00);
    idle(6);
    check("R12 no spurious", rd_data, 8'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule